// File: doc/BRIEF.md
# Strided Burst Address Generator

This block produces the request sequence for one memory-mapped data mover. A transfer is started with a start address, a length in bytes, a stride counted in data words and a burst count. From these the block emits a series of requests, each giving a byte address and a beat count, over a valid/ready handshake. Alongside the requests it reports how many bytes of the transfer are still to be requested.

The stride sets the distance between consecutive word accesses. A stride of one walks memory in order, zero hammers a single address, and larger values step over words, for example to decimate a buffer or to read one column of a frame. Bursting is only meaningful for consecutive words, so a burst longer than one beat is issued only when the stride is one. The per-transfer burst count is limited by a build-time maximum. The last request of a transfer is cut short so that it never reaches past the programmed length.

Top module: `stride_burst_agen`

## Requirements
- R1: Out of reset `busy` and `req_valid` are low and `bytes_left` is zero.
- R2: A `start` pulse seen while idle with a non-zero `cfg_len` raises `busy` and `req_valid` on the next cycle. At that point `req_addr` equals `cfg_addr` and `bytes_left` equals `cfg_len`.
- R3: After each accepted request the address advances by the beat count times the stride times `DATA_BYTES`, modulo 2^ADDR_W. A stride of 0 repeats one address and a stride of 2 skips every other word.
- R4: When the stride is not 1, every request carries a beat count of 1.
- R5: When the stride is 1 and `cfg_burst` lies between 1 and the smaller of 128 and `MAX_BURST`, full requests carry exactly `cfg_burst` beats.
- R6: When the stride is 1 and `cfg_burst` is 0, or exceeds `MAX_BURST`, or exceeds 128, full requests carry `MAX_BURST` beats.
- R7: A transfer covers ceil(`cfg_len`/`DATA_BYTES`) words. The final request carries only the words that remain, and `req_last` is high on that request and on no other.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_beats` and `req_last` hold their values.
- R9: Each accepted request lowers `bytes_left` by its beat count times `DATA_BYTES`, stopping at zero. The cycle after the final request is accepted, `busy` and `req_valid` are low.
- R10: A `start` seen while `busy` is high has no effect, including in the cycle of the final handshake. A `start` with `cfg_len` of zero issues no request and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the cfg_* values (taken only when idle) |
| cfg_addr | input | ADDR_W | First byte address |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_stride | input | STRIDE_W | Word distance between accesses |
| cfg_burst | input | 8 | Requested burst count; 0 selects the build-time maximum |
| busy | output | 1 | A transfer is in progress |
| req_valid | output | 1 | A request is offered |
| req_ready | input | 1 | The request is taken this cycle |
| req_addr | output | ADDR_W | Byte address of the request |
| req_beats | output | BEAT_W | Beats in the request |
| req_last | output | 1 | Final request of the transfer |
| bytes_left | output | LEN_W | Bytes not yet covered by accepted requests |

## Verification
The riskiest overlap is the final handshake of a transfer arriving in the same cycle as a fresh `start` with a different configuration. The bench provokes this on every transfer by raising `start` exactly when it accepts the last request. It then requires the block to be idle one cycle later, with no request offered and `bytes_left` at zero. A second overlap is a stall on a shortened final burst. The ready pattern is irregular, so stalls fall on full, final and single-beat requests alike, and each held request is compared against the same expected value until it is taken.

// File: rtl/sbag_pkg.sv
package sbag_pkg;

    typedef enum logic {
        SBAG_IDLE = 1'b0,
        SBAG_RUN  = 1'b1
    } sbag_state_e;

    // Field cap of the per-transfer burst value, independent of MAX_BURST.
    localparam int SBAG_FIELD_CAP = 128;

endpackage

// File: rtl/sbag_burst_pick.sv
module sbag_burst_pick
    import sbag_pkg::*;
#(
    parameter int MAX_BURST = 16,
    parameter int BEAT_W    = 5
) (
    input  logic [7:0]        prog,
    input  logic              seq,
    output logic [BEAT_W-1:0] eff
);

    logic in_range;

    // The accepted range ends at whichever is smaller: build limit or field cap.
    generate
        if (MAX_BURST < SBAG_FIELD_CAP) begin : g_cap_build
            assign in_range = (prog != 8'd0) && (int'(prog) <= MAX_BURST);
        end else begin : g_cap_field
            assign in_range = (prog != 8'd0) && (int'(prog) <= SBAG_FIELD_CAP);
        end
    endgenerate

    always_comb begin
        if (!seq) begin
            eff = BEAT_W'(1);
        end else if (in_range) begin
            eff = BEAT_W'(prog);
        end else begin
            eff = BEAT_W'(MAX_BURST);
        end
    end

endmodule

// File: rtl/sbag_step_calc.sv
module sbag_step_calc #(
    parameter int ADDR_W     = 32,
    parameter int STRIDE_W   = 8,
    parameter int DATA_BYTES = 4
) (
    input  logic [STRIDE_W-1:0] stride,
    output logic [ADDR_W-1:0]   step,
    output logic                seq
);

    localparam int LOG_DB = $clog2(DATA_BYTES);

    always_comb begin
        step = ADDR_W'(stride) << LOG_DB;
        seq  = (stride == STRIDE_W'(1));
    end

endmodule

// File: rtl/sbag_beat_limit.sv
module sbag_beat_limit #(
    parameter int LEN_W  = 20,
    parameter int BEAT_W = 5
) (
    input  logic [LEN_W-1:0]  words_left,
    input  logic [BEAT_W-1:0] burst,
    output logic [BEAT_W-1:0] beats,
    output logic              last
);

    always_comb begin
        last  = (words_left <= LEN_W'(burst));
        beats = last ? BEAT_W'(words_left) : burst;
    end

endmodule

// File: rtl/stride_burst_agen.sv
module stride_burst_agen
    import sbag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 20,
    parameter int STRIDE_W   = 8,
    parameter int DATA_BYTES = 4,
    parameter int MAX_BURST  = 16,
    localparam int BEAT_W    = $clog2(MAX_BURST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [7:0]          cfg_burst,
    output logic                busy,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [BEAT_W-1:0]   req_beats,
    output logic                req_last,
    output logic [LEN_W-1:0]    bytes_left
);

    localparam int LOG_DB = $clog2(DATA_BYTES);

    typedef struct packed {
        sbag_state_e        state;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   words;
        logic [LEN_W-1:0]   bytes;
        logic [ADDR_W-1:0]  step;
        logic               seq;
        logic [BEAT_W-1:0]  burst;
    } sbag_regs_t;

    sbag_regs_t cur_q, nxt_d;

    logic [ADDR_W-1:0] cfg_step;
    logic              cfg_seq;
    logic [BEAT_W-1:0] cfg_eff_burst;
    logic [LEN_W:0]    cfg_words_wide;
    logic [BEAT_W-1:0] beats;
    logic              last;
    logic [ADDR_W-1:0] advance;
    logic [LEN_W-1:0]  consumed;
    logic              accept;

    sbag_step_calc #(
        .ADDR_W    (ADDR_W),
        .STRIDE_W  (STRIDE_W),
        .DATA_BYTES(DATA_BYTES)
    ) u_step (
        .stride(cfg_stride),
        .step  (cfg_step),
        .seq   (cfg_seq)
    );

    sbag_burst_pick #(
        .MAX_BURST(MAX_BURST),
        .BEAT_W   (BEAT_W)
    ) u_pick (
        .prog(cfg_burst),
        .seq (cfg_seq),
        .eff (cfg_eff_burst)
    );

    sbag_beat_limit #(
        .LEN_W (LEN_W),
        .BEAT_W(BEAT_W)
    ) u_limit (
        .words_left(cur_q.words),
        .burst     (cur_q.burst),
        .beats     (beats),
        .last      (last)
    );

    always_comb begin
        cfg_words_wide = ({1'b0, cfg_len} + (LEN_W+1)'(DATA_BYTES - 1)) >> LOG_DB;
        accept         = (cur_q.state == SBAG_RUN) && req_ready;
        advance        = cur_q.seq ? (ADDR_W'(beats) << LOG_DB) : cur_q.step;
        consumed       = LEN_W'(beats) << LOG_DB;

        nxt_d = cur_q;
        case (cur_q.state)
            SBAG_IDLE: begin
                if (start && (cfg_len != '0)) begin
                    nxt_d.state = SBAG_RUN;
                    nxt_d.addr  = cfg_addr;
                    nxt_d.words = cfg_words_wide[LEN_W-1:0];
                    nxt_d.bytes = cfg_len;
                    nxt_d.step  = cfg_step;
                    nxt_d.seq   = cfg_seq;
                    nxt_d.burst = cfg_eff_burst;
                end
            end
            SBAG_RUN: begin
                if (accept) begin
                    nxt_d.addr  = cur_q.addr + advance;
                    nxt_d.words = cur_q.words - LEN_W'(beats);
                    nxt_d.bytes = (cur_q.bytes > consumed) ? (cur_q.bytes - consumed) : '0;
                    if (last) begin
                        nxt_d.state = SBAG_IDLE;
                    end
                end
            end
            default: nxt_d.state = SBAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: SBAG_IDLE, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy       = (cur_q.state == SBAG_RUN);
    assign req_valid  = (cur_q.state == SBAG_RUN);
    assign req_addr   = cur_q.addr;
    assign req_beats  = beats;
    assign req_last   = (cur_q.state == SBAG_RUN) && last;
    assign bytes_left = cur_q.bytes;

endmodule

// File: rtl/sbag_checker.sv
module sbag_checker #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 20,
    parameter int MAX_BURST = 16,
    parameter int BEAT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BEAT_W-1:0] req_beats,
    input logic              req_last,
    input logic [LEN_W-1:0]  bytes_left
);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_beats) && $stable(req_last))); // R8

    AST_BEATS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_beats != '0) && (int'(req_beats) <= MAX_BURST))); // R6

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!req_valid && !req_last)); // R9

    AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_last) |=> (!busy && bytes_left == '0)); // R9

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(req_ready && req_last)) |=> busy); // R10

    AST_BYTES_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_last) |=> (bytes_left < $past(bytes_left))); // R9

endmodule

bind stride_burst_agen sbag_checker #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .MAX_BURST(MAX_BURST),
    .BEAT_W   (BEAT_W)
) u_sbag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_beats (req_beats),
    .req_last  (req_last),
    .bytes_left(bytes_left)
);

// File: tb/stride_burst_agen_test.sv
module stride_burst_agen_test;

    localparam int AW  = 32;
    localparam int LW  = 20;
    localparam int SW  = 8;
    localparam int DB  = 4;
    localparam int MB  = 16;
    localparam int BW  = $clog2(MB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [LW-1:0] cfg_len = '0;
    logic [SW-1:0] cfg_stride = '0;
    logic [7:0]    cfg_burst = '0;
    logic          busy, req_valid, req_last;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [BW-1:0] req_beats;
    logic [LW-1:0] bytes_left;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    stride_burst_agen #(
        .ADDR_W(AW), .LEN_W(LW), .STRIDE_W(SW), .DATA_BYTES(DB), .MAX_BURST(MB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_stride(cfg_stride), .cfg_burst(cfg_burst),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_beats(req_beats), .req_last(req_last),
        .bytes_left(bytes_left)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int eff_burst(input int stride, input int prog);
        if (stride != 1) return 1;
        if (prog == 0 || prog > MB || prog > 128) return MB;
        return prog;
    endfunction

    task automatic run_one(input logic [AW-1:0] a0, input int len, input int stride,
                           input int prog, input int salt);
        logic [AW-1:0] e_addr;
        int e_words, e_bytes, eb, e_beats, guard;
        bit e_last, rdy;
        string tag;
        e_addr  = a0;
        e_words = (len + DB - 1) / DB;
        e_bytes = len;
        eb      = eff_burst(stride, prog);
        cfg_addr = a0; cfg_len = LW'(len); cfg_stride = SW'(stride); cfg_burst = 8'(prog);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            check(!busy && !req_valid, "R10 zero length", {busy, req_valid}, 0);
            return;
        end
        check(busy && req_valid, "R2 valid after start", {busy, req_valid}, 3);
        check(bytes_left == LW'(len), "R2 bytes_left", bytes_left, len);
        guard = 0;
        while (e_words > 0 && guard < 4000) begin
            guard++;
            e_beats = (e_words < eb) ? e_words : eb;
            e_last  = (e_words <= eb);
            if (stride != 1)      tag = "R4";
            else if (e_last)      tag = "R7";
            else if (eb == prog)  tag = "R5";
            else                  tag = "R6";
            check(req_valid == 1'b1, "R8 valid held", req_valid, 1);
            check(req_addr == e_addr, "R3 address", req_addr, e_addr);
            check(int'(req_beats) == e_beats, tag, req_beats, e_beats);
            check(req_last == e_last, "R7 last flag", req_last, e_last);
            check(int'(bytes_left) == e_bytes, "R9 bytes_left", bytes_left, e_bytes);
            rdy = ((cyc + salt) % 5 != 1) && ((cyc + salt) % 7 != 3);
            req_ready = rdy;
            if (rdy && e_last) begin
                // R10 probe: new start in the final handshake cycle
                start = 1'b1; cfg_len = LW'(8); cfg_stride = SW'(1); cfg_addr = ~a0;
            end
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            req_ready = 1'b0;
            if (rdy) begin
                e_addr  = e_addr + AW'(e_beats * stride * DB);
                e_words = e_words - e_beats;
                e_bytes = (e_bytes > e_beats * DB) ? e_bytes - e_beats * DB : 0;
            end
        end
        check(guard < 4000, "R9 transfer ends", guard, 0);
        check(!busy && !req_valid, "R10 idle after final", {busy, req_valid}, 0);
        check(bytes_left == '0, "R9 bytes_left zero", bytes_left, 0);
    endtask

    initial begin
        int strides[4] = '{0, 1, 2, 5};
        int bursts[10] = '{0, 1, 2, 4, 8, 16, 17, 32, 128, 200};
        int lens[10]   = '{0, 1, 3, 4, 5, 16, 63, 64, 65, 130};
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !req_valid && bytes_left == '0, "R1 reset state",
              {busy, req_valid, bytes_left}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid, "R1 idle after reset", {busy, req_valid}, 0);
        k = 0;
        foreach (strides[s]) begin
            foreach (bursts[b]) begin
                foreach (lens[l]) begin
                    logic [AW-1:0] base;
                    base = (k % 17 == 5) ? 32'hFFFF_FFF0 : 32'h1000_0000 + AW'(k * 36);
                    run_one(base, lens[l], strides[s], bursts[b], k);
                    k++;
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule